// File: doc/BRIEF.md
# Window-Gated Pair-Line Prefetcher

This block sits beside a cache and watches its fill events. Each fill carries the virtual address that caused it and the physical address of the filled block. When prefetching is enabled and the virtual address lies inside a window that software has programmed, the block asks for the other 32-byte half of the 64-byte pair that holds the filled line. The requested address is the fill's physical address with bit 5 inverted and bits 4..0 cleared, which is the fill address plus or minus 0x20, aligned to a line.

Software programs the window bounds, an element-size value and an enable bit through a single-cycle write port. The element-size value is passed straight out to the downstream pointer-extraction logic. A request waits in one output slot until the consumer takes it with a valid/ready handshake. A qualifying fill that finds the slot still occupied is dropped and counted in a saturating counter. A request for the same line as the most recently issued one is suppressed.

Top module: `pair_line_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0, `drop_count` is 0, `elem_size` is 0, both bounds are 0 and prefetching is disabled.
- R2: A write with `cfg_wr` high stores `cfg_wdata` according to `cfg_sel`: 0 sets the lower bound, 1 the upper bound, 2 the element size (low `ESZ_W` bits), 3 the control word (bit 0 = enable). A fill in the same cycle as the write sees the old value, and a fill in the next cycle sees the new one.
- R3: A fill qualifies only if lower bound <= `fill_vaddr` <= upper bound, with both ends inclusive.
- R4: The requested address is `fill_paddr` with bit 5 inverted and bits 4..0 forced to 0. All higher bits are unchanged.
- R5: A qualifying fill, sampled at clock edge N into an empty or draining slot, shows up as `pf_valid`=1 with its address after edge N.
- R6: While `pf_valid` is 1 and `pf_ready` is 0, the request and its address stay unchanged. A cycle with both high completes the transfer.
- R7: A qualifying, non-duplicate fill that arrives while the slot holds an unaccepted request (`pf_valid`=1, `pf_ready`=0) is dropped. `drop_count` then increments and saturates at its maximum.
- R8: A qualifying fill whose target equals the most recently issued target produces no request and is not counted as a drop.
- R9: While the enable bit is 0, no fill produces a request.
- R10: `elem_size` always shows the element size that was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | VA_W | Configuration write data |
| fill_valid | input | 1 | Cache fill event present |
| fill_vaddr | input | VA_W | Virtual address of the fill |
| fill_paddr | input | PA_W | Physical address of the filled block |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer accepts the request |
| pf_addr | output | PA_W | Physical line address to fetch |
| elem_size | output | ESZ_W | Programmed element size |
| drop_count | output | DROP_W | Saturating count of dropped fills |

## Verification
A bound that is wrong or off by one would either let a request appear on the cycle after a fill at a window edge, or fail to make one there. Boundary addresses therefore show such a fault within one cycle. A corrupted last-target register shows up at the next fill into the same pair, as a repeated request or a missing one. A fault in the slot or the counter shows up while the consumer stalls, as an address that changes, a request that vanishes, or a count that wraps instead of holding.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [1:0] {
    CSEL_LOWER = 2'd0,
    CSEL_UPPER = 2'd1,
    CSEL_ESIZE = 2'd2,
    CSEL_CTRL  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pfx_cfg_regs.sv
module pfx_cfg_regs
  import pfx_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int ESZ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [VA_W-1:0]  wdata,
  output logic [VA_W-1:0]  lower,
  output logic [VA_W-1:0]  upper,
  output logic [ESZ_W-1:0] esize,
  output logic             enable
);
  logic [VA_W-1:0]  lower_q, lower_d;
  logic [VA_W-1:0]  upper_q, upper_d;
  logic [ESZ_W-1:0] esize_q, esize_d;
  logic             en_q, en_d;
  cfg_sel_e         sel_e;

  assign sel_e = cfg_sel_e'(sel);

  always_comb begin
    lower_d = lower_q;
    upper_d = upper_q;
    esize_d = esize_q;
    en_d    = en_q;
    case (sel_e)
      CSEL_LOWER: lower_d = wdata;
      CSEL_UPPER: upper_d = wdata;
      CSEL_ESIZE: esize_d = wdata[ESZ_W-1:0];
      CSEL_CTRL:  en_d    = wdata[0];
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q <= '0;
      upper_q <= '0;
      esize_q <= '0;
      en_q    <= 1'b0;
    end else if (wr) begin
      lower_q <= lower_d;
      upper_q <= upper_d;
      esize_q <= esize_d;
      en_q    <= en_d;
    end
  end

  assign lower  = lower_q;
  assign upper  = upper_q;
  assign esize  = esize_q;
  assign enable = en_q;
endmodule

// File: rtl/pfx_qualify.sv
module pfx_qualify #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int LINE_SH = 5
) (
  input  logic            fill_valid,
  input  logic            enable,
  input  logic [VA_W-1:0] lower,
  input  logic [VA_W-1:0] upper,
  input  logic [VA_W-1:0] vaddr,
  input  logic [PA_W-1:0] paddr,
  output logic            hit,
  output logic [PA_W-1:0] target
);
  localparam logic [PA_W-1:0] FLIP    = PA_W'(1) << LINE_SH;
  localparam logic [PA_W-1:0] LOWMASK = FLIP - PA_W'(1);

  logic in_window;

  always_comb begin
    in_window = (vaddr >= lower) && (vaddr <= upper);
    hit       = fill_valid && enable && in_window;
    target    = (paddr ^ FLIP) & ~LOWMASK;
  end
endmodule

// File: rtl/pfx_req_slot.sv
module pfx_req_slot #(
  parameter int PA_W   = 32,
  parameter int DROP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [PA_W-1:0]   target,
  input  logic              ready,
  output logic              valid,
  output logic [PA_W-1:0]   addr,
  output logic [DROP_W-1:0] drops
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic              vld_q, vld_d;
  logic              seen_q, seen_d;
  logic [PA_W-1:0]   addr_q, addr_d;
  logic [DROP_W-1:0] cnt_q, cnt_d;
  logic              dup, room, load, drop;

  always_comb begin
    dup    = seen_q && (target == addr_q);
    room   = !vld_q || ready;
    load   = hit && !dup && room;
    drop   = hit && !dup && !room;
    vld_d  = load ? 1'b1 : (ready ? 1'b0 : vld_q);
    seen_d = seen_q || load;
    addr_d = load ? target : addr_q;
    cnt_d  = (drop && (cnt_q != DROP_MAX)) ? cnt_q + DROP_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      seen_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      seen_q <= seen_d;
      if (load) addr_q <= addr_d;
      if (drop) cnt_q  <= cnt_d;
    end
  end

  assign valid = vld_q;
  assign addr  = addr_q;
  assign drops = cnt_q;
endmodule

// File: rtl/pair_line_prefetcher.sv
module pair_line_prefetcher #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ESZ_W   = 8,
  parameter int DROP_W  = 4,
  parameter int LINE_SH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [VA_W-1:0]   cfg_wdata,
  input  logic              fill_valid,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [PA_W-1:0]   fill_paddr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [PA_W-1:0]   pf_addr,
  output logic [ESZ_W-1:0]  elem_size,
  output logic [DROP_W-1:0] drop_count
);
  logic            rst_meta_q, rst_sync_n;
  logic [VA_W-1:0] cfg_lo, cfg_hi;
  logic            cfg_en;
  logic            fill_hit;
  logic [PA_W-1:0] fill_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pfx_cfg_regs #(.VA_W(VA_W), .ESZ_W(ESZ_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (cfg_wr),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .lower  (cfg_lo),
    .upper  (cfg_hi),
    .esize  (elem_size),
    .enable (cfg_en)
  );

  pfx_qualify #(.VA_W(VA_W), .PA_W(PA_W), .LINE_SH(LINE_SH)) u_qual (
    .fill_valid (fill_valid),
    .enable     (cfg_en),
    .lower      (cfg_lo),
    .upper      (cfg_hi),
    .vaddr      (fill_vaddr),
    .paddr      (fill_paddr),
    .hit        (fill_hit),
    .target     (fill_target)
  );

  pfx_req_slot #(.PA_W(PA_W), .DROP_W(DROP_W)) u_slot (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hit    (fill_hit),
    .target (fill_target),
    .ready  (pf_ready),
    .valid  (pf_valid),
    .addr   (pf_addr),
    .drops  (drop_count)
  );
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int DROP_W  = 4,
  parameter int LINE_SH = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              fill_valid,
  input logic [VA_W-1:0]   fill_vaddr,
  input logic [PA_W-1:0]   fill_paddr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [PA_W-1:0]   pf_addr,
  input logic [DROP_W-1:0] drop_count,
  input logic [VA_W-1:0]   cfg_lo,
  input logic [VA_W-1:0]   cfg_hi,
  input logic              cfg_en
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R6

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pf_valid |-> pf_addr[LINE_SH-1:0] == '0); // R4

  AST_PARTNER_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pf_valid) |-> (pf_addr[LINE_SH] != $past(fill_paddr[LINE_SH])) &&
      (pf_addr[PA_W-1:LINE_SH+1] == $past(fill_paddr[PA_W-1:LINE_SH+1]))); // R4

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_valid && ((fill_vaddr < cfg_lo) || (fill_vaddr > cfg_hi))
      |=> pf_valid == $past(pf_valid && !pf_ready)); // R3

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_valid && !cfg_en |=> pf_valid == $past(pf_valid && !pf_ready)); // R9

  AST_DROP_SATURATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drop_count == DROP_MAX |=> drop_count == DROP_MAX); // R7

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(drop_count) |-> drop_count == $past(drop_count) + DROP_W'(1)); // R7
endmodule

bind pair_line_prefetcher pfx_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .DROP_W(DROP_W), .LINE_SH(LINE_SH)
) u_pfx_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .fill_valid (fill_valid),
  .fill_vaddr (fill_vaddr),
  .fill_paddr (fill_paddr),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_addr    (pf_addr),
  .drop_count (drop_count),
  .cfg_lo     (cfg_lo),
  .cfg_hi     (cfg_hi),
  .cfg_en     (cfg_en)
);

// File: tb/test_pair_line_prefetcher.sv
`timescale 1ns/1ps
module test_pair_line_prefetcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        fill_valid;
  logic [31:0] fill_vaddr;
  logic [31:0] fill_paddr;
  logic        pf_valid;
  logic        pf_ready;
  logic [31:0] pf_addr;
  logic [7:0]  elem_size;
  logic [3:0]  drop_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pair_line_prefetcher i_pair_line_prefetcher (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fill_valid(fill_valid), .fill_vaddr(fill_vaddr),
    .fill_paddr(fill_paddr), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .elem_size(elem_size), .drop_count(drop_count)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic        exp_v;
    logic [31:0] exp_a;
  } vec_t;

  // Window 0x1000..0x1FFF; ready held high so each request drains.
  localparam vec_t VECS [0:8] = '{
    '{32'h0000_1000, 32'h8000_0040, 1'b1, 32'h8000_0060}, // lower edge
    '{32'h0000_1FFF, 32'h8000_0065, 1'b1, 32'h8000_0040}, // upper edge
    '{32'h0000_0FFF, 32'h8000_0100, 1'b0, 32'h0},         // below window
    '{32'h0000_2000, 32'h8000_0100, 1'b0, 32'h0},         // above window
    '{32'h0000_1800, 32'h1234_56A7, 1'b1, 32'h1234_5680},
    '{32'h0000_1801, 32'h1234_5690, 1'b1, 32'h1234_56A0},
    '{32'h0000_1802, 32'h1234_56B8, 1'b1, 32'h1234_5680},
    '{32'h0000_1803, 32'h1234_5681, 1'b1, 32'h1234_56A0},
    '{32'h0000_1804, 32'h1234_5690, 1'b0, 32'h0}          // duplicate
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    tick();
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    fill_valid = 1'b0; fill_vaddr = '0; fill_paddr = '0; pf_ready = 1'b0;
    repeat (3) tick();
    chk("R1 pf_valid", {31'b0, pf_valid}, 32'd0);
    chk("R1 drop_count", {28'b0, drop_count}, 32'd0);
    chk("R1 elem_size", {24'b0, elem_size}, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 / R9: bounds zero and disabled -> fill at vaddr 0 gives nothing
    fill_valid = 1'b1; fill_vaddr = 32'h0; fill_paddr = 32'h7000_0000;
    tick();
    fill_valid = 1'b0;
    chk("R1 no request from reset state", {31'b0, pf_valid}, 32'd0);

    cfg_write(2'd0, 32'h0000_1000);
    cfg_write(2'd1, 32'h0000_1FFF);
    cfg_write(2'd2, 32'h0000_00A5);
    chk("R10 elem_size", {24'b0, elem_size}, 32'h0000_00A5);

    // R9: window set, still disabled
    fill_valid = 1'b1; fill_vaddr = 32'h0000_1400; fill_paddr = 32'h7000_0000;
    tick();
    fill_valid = 1'b0;
    chk("R9 disabled", {31'b0, pf_valid}, 32'd0);

    cfg_write(2'd3, 32'h1);
    pf_ready = 1'b1;

    foreach (VECS[i]) begin
      fill_valid = 1'b1; fill_vaddr = VECS[i].va; fill_paddr = VECS[i].pa;
      tick();
      fill_valid = 1'b0;
      chk($sformatf("R3/R5/R8 vector %0d valid", i), {31'b0, pf_valid}, {31'b0, VECS[i].exp_v});
      if (VECS[i].exp_v)
        chk($sformatf("R4 vector %0d address", i), pf_addr, VECS[i].exp_a);
      tick();
      chk($sformatf("R6 vector %0d drained", i), {31'b0, pf_valid}, 32'd0);
    end
    chk("R8 duplicate not counted", {28'b0, drop_count}, 32'd0);

    // R2: same-cycle write uses old lower bound
    cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_3000;
    fill_valid = 1'b1; fill_vaddr = 32'h0000_1000; fill_paddr = 32'h0000_0000;
    tick();
    cfg_wr = 1'b0;
    chk("R2 old bound same cycle", {31'b0, pf_valid}, 32'd1);
    chk("R2 old bound address", pf_addr, 32'h0000_0020);
    fill_paddr = 32'h0000_0100;
    tick();
    fill_valid = 1'b0;
    chk("R2 new bound next cycle", {31'b0, pf_valid}, 32'd0);
    cfg_write(2'd0, 32'h0000_1000);

    // R6 / R7: stalled consumer, drops saturate
    pf_ready = 1'b0;
    fill_valid = 1'b1; fill_vaddr = 32'h0000_1100; fill_paddr = 32'h4000_0000;
    tick();
    chk("R5 stall load", {31'b0, pf_valid}, 32'd1);
    chk("R4 stall load address", pf_addr, 32'h4000_0020);
    fill_paddr = 32'h5000_0000;
    tick();
    chk("R7 first drop", {28'b0, drop_count}, 32'd1);
    for (int k = 1; k < 20; k++) begin
      fill_paddr = 32'h5000_0000 + 32'(k) * 32'h40;
      tick();
    end
    fill_valid = 1'b0;
    chk("R7 saturated", {28'b0, drop_count}, 32'd15);
    chk("R6 held valid", {31'b0, pf_valid}, 32'd1);
    chk("R6 held address", pf_addr, 32'h4000_0020);
    pf_ready = 1'b1;
    tick();
    chk("R6 accepted", {31'b0, pf_valid}, 32'd0);

    // R6: accept and new fill in the same cycle -> reload, no drop
    pf_ready = 1'b0;
    fill_valid = 1'b1; fill_vaddr = 32'h0000_1200; fill_paddr = 32'h4000_0100;
    tick();
    pf_ready = 1'b1; fill_paddr = 32'h4000_0220;
    tick();
    fill_valid = 1'b0;
    chk("R6 back-to-back valid", {31'b0, pf_valid}, 32'd1);
    chk("R6 back-to-back address", pf_addr, 32'h4000_0200);
    chk("R7 no drop on accept", {28'b0, drop_count}, 32'd15);
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule